// File: doc/BRIEF.md
# Shared BCH Parity and Syndrome Unit

This block serves a memory controller that guards each 256-bit data word with a binary BCH code able to repair two flipped bits. One datapath does two jobs. When writing, the controller presents the data word and gets back 18 check bits to store beside it. When reading, the controller presents the whole 274-bit stored word and gets back the two syndromes that a later error-locating stage needs. A codeword that was read back intact gives two zero syndromes.

Arithmetic is in GF(2^9), built on the primitive polynomial x^9+x^4+1. The generator polynomial is the product of the minimal polynomials of alpha and alpha^3. Both jobs start by reducing a 274-bit polynomial modulo each of these two degree-9 factors, and that reduction logic is built only once. A small fixed linear map then turns the two 9-bit remainders into the result. For writing, the map recombines the two remainders into a remainder modulo the generator. For reading, the map evaluates them at alpha and at alpha^3. A write and a read are never requested in the same cycle. Each request is fully processed in one cycle and its result is registered.

Top module: `bch_shared_codec`

## Requirements
- R1: While reset is held and in the cycle after it is released, out_valid is 0 and out_res is all zeros.
- R2: out_valid is 1 in exactly the cycle that follows a cycle in which in_valid was 1, and it is 0 after any cycle in which in_valid was 0.
- R3: With in_mode = 0 (encode), the data sits in in_word[273:18], where in_word bit j is the coefficient of x^j. Place the returned out_res[17:0] in bits 17:0 to form the codeword c(x). Then c(alpha) = 0 and c(alpha^3) = 0, where alpha is a root of x^9+x^4+1 and field element bit k is the coefficient of alpha^k.
- R4: In encode mode, in_word[17:0] has no effect on out_res.
- R5: With in_mode = 1 (decode), out_res[8:0] equals r(alpha), where r(x) is in_word read as a polynomial.
- R6: In decode mode, out_res[17:9] equals r(alpha^3).
- R7: Decoding a codeword that was formed as in R3 gives out_res = 0. Decoding that codeword with one bit flipped at position i gives alpha^i and alpha^3i. With bits a and b flipped it gives the sums of the two.
- R8: After a cycle with in_valid = 0, out_res keeps its value.
- R9: out_mode repeats the in_mode of the request whose result is on out_res. Encode and decode requests may alternate on consecutive cycles with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request present this cycle |
| in_mode | input | 1 | 0 = compute check bits, 1 = compute syndromes |
| in_word | input | 274 | Data in bits 273:18 (encode) or full received word (decode) |
| out_valid | output | 1 | Result of last cycle's request is present |
| out_mode | output | 1 | Mode of the result on out_res |
| out_res | output | 18 | Check bits (encode) or {S3, S1} (decode) |

## Verification
Every result appears exactly one clock edge after the cycle in which its request is presented. The bench drives a request on a falling edge and reads out_valid, out_mode and out_res on the next falling edge, which lies after the single register. In the back-to-back test the bench reads each result on the falling edge that follows its own request while it drives the next request, so a result slipping by a cycle is caught as a mismatch. The hold check reads the outputs on idle falling edges and compares them with the value that was last captured.

// File: rtl/bch_code_pkg.sv
`timescale 1ns/1ps
// Package: code constants and elaboration-time GF(2^9) helpers.
// Assumes the primitive polynomial has degree GF_M and that alpha^3 has
// GF_M distinct conjugates, which holds for GF(2^9).
package bch_code_pkg;
    localparam int GF_M = 9;
    localparam logic [GF_M:0] GF_PRIM = 10'h211;          // x^9 + x^4 + 1
    localparam int GF_ORDER = (1 << GF_M) - 1;
    localparam int DATA_W = 256;
    localparam int PAR_W = 2 * GF_M;
    localparam int CW_W = DATA_W + PAR_W;

    typedef enum logic {MODE_ENC = 1'b0, MODE_DEC = 1'b1} bch_mode_e;

    // Product of two residues modulo a monic degree-GF_M polynomial.
    function automatic logic [GF_M-1:0] mul_mod(input logic [GF_M-1:0] a,
                                                input logic [GF_M-1:0] b,
                                                input logic [GF_M:0] poly);
        logic [GF_M-1:0] acc;
        logic [GF_M-1:0] sh;
        acc = '0;
        sh = a;
        for (int k = 0; k < GF_M; k++) begin
            if (b[k]) acc = acc ^ sh;
            if (sh[GF_M-1]) sh = {sh[GF_M-2:0], 1'b0} ^ poly[GF_M-1:0];
            else            sh = {sh[GF_M-2:0], 1'b0};
        end
        return acc;
    endfunction

    // x^e modulo poly, by square and multiply over 16 exponent bits.
    function automatic logic [GF_M-1:0] pow_mod(input int e, input logic [GF_M:0] poly);
        logic [GF_M-1:0] res;
        logic [15:0] eb;
        res = 1;
        eb = 16'(e);
        for (int k = 15; k >= 0; k--) begin
            res = mul_mod(res, res, poly);
            if (eb[k]) res = mul_mod(res, GF_M'(2), poly);
        end
        return res;
    endfunction

    // Minimal polynomial of alpha^3: product of (x + beta) over its conjugates.
    function automatic logic [GF_M:0] min_poly3();
        logic [GF_M:0][GF_M-1:0] c;
        logic [GF_M-1:0] beta;
        logic [GF_M:0] out;
        int e;
        c = '0;
        c[0] = 1;
        e = 3;
        for (int j = 0; j < GF_M; j++) begin
            beta = pow_mod(e, GF_PRIM);
            for (int k = GF_M; k >= 0; k--) begin
                if (k > 0) c[k] = c[k-1] ^ mul_mod(c[k], beta, GF_PRIM);
                else       c[k] = mul_mod(c[k], beta, GF_PRIM);
            end
            e = (e * 2) % GF_ORDER;
        end
        for (int k = 0; k <= GF_M; k++) out[k] = c[k][0];
        return out;
    endfunction

    // Inverse of the map (parity mod g) -> {rem mod m3, rem mod m1}, row per parity bit.
    function automatic logic [PAR_W-1:0][PAR_W-1:0] crt_inv();
        logic [PAR_W-1:0][2*PAR_W-1:0] aug;
        logic [PAR_W-1:0][PAR_W-1:0] inv;
        logic [2*PAR_W-1:0] tmp;
        logic [GF_M:0] m3;
        logic [GF_M-1:0] c1;
        logic [GF_M-1:0] c3;
        int piv;
        m3 = min_poly3();
        aug = '0;
        for (int j = 0; j < PAR_W; j++) begin
            c1 = pow_mod(j, GF_PRIM);
            c3 = pow_mod(j, m3);
            for (int r = 0; r < GF_M; r++) begin
                aug[r][j] = c1[r];
                aug[r+GF_M][j] = c3[r];
            end
        end
        for (int r = 0; r < PAR_W; r++) aug[r][PAR_W+r] = 1'b1;
        for (int c = 0; c < PAR_W; c++) begin
            piv = c;
            for (int r = PAR_W - 1; r >= c; r--) if (aug[r][c]) piv = r;
            tmp = aug[c];
            aug[c] = aug[piv];
            aug[piv] = tmp;
            for (int r = 0; r < PAR_W; r++) if (r != c && aug[r][c]) aug[r] = aug[r] ^ aug[c];
        end
        for (int r = 0; r < PAR_W; r++) inv[r] = aug[r][2*PAR_W-1:PAR_W];
        return inv;
    endfunction
endpackage

// File: rtl/bch_rem_unit.sv
`timescale 1ns/1ps
// Module: remainder of an NW-bit polynomial modulo a fixed monic degree-M
// polynomial, as a parallel XOR of precomputed columns x^i mod POLY.
// Assumes M equals the package field degree.
module bch_rem_unit
    import bch_code_pkg::*;
#(
    parameter int NW = CW_W,
    parameter int M = GF_M,
    parameter logic [M:0] POLY = GF_PRIM
) (
    input  logic [NW-1:0] word,
    output logic [M-1:0]  rem
);
    logic [NW-1:0][M-1:0] term;

    for (genvar i = 0; i < NW; i++) begin : g_col
        localparam logic [M-1:0] COL = pow_mod(i, POLY);
        assign term[i] = word[i] ? COL : '0;
    end

    // Sum every selected column into the remainder.
    always_comb begin
        rem = '0;
        for (int i = 0; i < NW; i++) rem = rem ^ term[i];
    end
endmodule

// File: rtl/bch_result_map.sv
`timescale 1ns/1ps
// Module: turns the two remainders into the result of the selected mode.
// Encode: recombine into the remainder modulo m1*m3 (the check bits).
// Decode: S1 is the m1 remainder itself; S3 is the m3 remainder at alpha^3.
module bch_result_map
    import bch_code_pkg::*;
#(
    parameter int M = GF_M,
    localparam int PW = 2 * M
) (
    input  logic          mode,
    input  logic [M-1:0]  rem1,
    input  logic [M-1:0]  rem3,
    output logic [PW-1:0] res
);
    localparam logic [PW-1:0][PW-1:0] INV = crt_inv();

    logic [M-1:0][M-1:0] s3_term;
    logic [M-1:0]        s3;
    logic [PW-1:0]       parity;
    logic [PW-1:0]       rem_pair;

    assign rem_pair = {rem3, rem1};

    for (genvar k = 0; k < M; k++) begin : g_s3
        localparam logic [M-1:0] A3K = pow_mod(3 * k, GF_PRIM);
        assign s3_term[k] = rem3[k] ? A3K : '0;
    end

    for (genvar r = 0; r < PW; r++) begin : g_par
        assign parity[r] = ^(INV[r] & rem_pair);
    end

    // Evaluate the m3 remainder at alpha^3.
    always_comb begin
        s3 = '0;
        for (int k = 0; k < M; k++) s3 = s3 ^ s3_term[k];
    end

    // Pick the result of the requested mode.
    always_comb begin
        if (mode == MODE_DEC) res = {s3, rem1};
        else                  res = parity;
    end
endmodule

// File: rtl/bch_shared_codec.sv
`timescale 1ns/1ps
// Module: top of the shared check-bit / syndrome unit. A single pair of
// remainder trees serves both modes; the result is registered one cycle
// after the request. Assumes encode and decode never share a cycle.
module bch_shared_codec
    import bch_code_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int M = GF_M,
    localparam int PW = 2 * M,
    localparam int NW = DW + PW,
    localparam logic [M:0] M3_POLY = min_poly3()
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_mode,
    input  logic [NW-1:0] in_word,
    output logic          out_valid,
    output logic          out_mode,
    output logic [PW-1:0] out_res
);
    logic [NW-1:0] shared_word;
    logic [M-1:0]  rem1;
    logic [M-1:0]  rem3;
    logic [PW-1:0] res_next;

    // Encode reduces data*x^PW, so the low check-bit slots are forced to zero.
    always_comb begin
        if (in_mode == MODE_DEC) shared_word = in_word;
        else                     shared_word = {in_word[NW-1:PW], {PW{1'b0}}};
    end

    bch_rem_unit #(.NW(NW), .M(M), .POLY(GF_PRIM)) u_rem1 (
        .word(shared_word),
        .rem (rem1)
    );

    bch_rem_unit #(.NW(NW), .M(M), .POLY(M3_POLY)) u_rem3 (
        .word(shared_word),
        .rem (rem3)
    );

    bch_result_map #(.M(M)) u_map (
        .mode(in_mode),
        .rem1(rem1),
        .rem3(rem3),
        .res (res_next)
    );

    // Capture the result of an accepted request; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_mode  <= 1'b0;
            out_res   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_mode <= in_mode;
                out_res  <= res_next;
            end
        end
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_res == '0)); // R1
    AST_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R2
    AST_NO_EXTRA_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R2
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_res)); // R8
    AST_MODE_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_mode == $past(in_mode))); // R9
endmodule

// File: tb/sim_bch_shared_codec.sv
`timescale 1ns/1ps
// Bench: sweeps single-bit data and error positions, plus pseudo-random
// words; expected syndromes come from direct evaluation at alpha, alpha^3.
module sim_bch_shared_codec;
    localparam int NW = 274;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_mode = 1'b0;
    logic [NW-1:0] in_word = '0;
    logic          out_valid;
    logic          out_mode;
    logic [17:0]   out_res;

    int  n_total = 0;
    int  n_fail = 0;
    bit  done = 0;
    logic [31:0] lcg = 32'h1234_5678;

    bch_shared_codec u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mode(in_mode),
        .in_word(in_word), .out_valid(out_valid), .out_mode(out_mode), .out_res(out_res)
    );

    always #2.5 clk = ~clk;

    function automatic logic [8:0] times_alpha(input logic [8:0] a);
        return {a[7:0], 1'b0} ^ (a[8] ? 9'h011 : 9'h000);
    endfunction

    // {r(alpha^3), r(alpha)} by walking powers of alpha.
    function automatic logic [17:0] synd(input logic [NW-1:0] w);
        logic [8:0] s1, s3, a, b;
        s1 = '0; s3 = '0; a = 9'd1; b = 9'd1;
        for (int i = 0; i < NW; i++) begin
            if (w[i]) begin s1 = s1 ^ a; s3 = s3 ^ b; end
            a = times_alpha(a);
            b = times_alpha(times_alpha(times_alpha(b)));
        end
        return {s3, s1};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [17:0] act, input logic [17:0] exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic next_rand(output logic [NW-1:0] w);
        logic [287:0] t;
        for (int k = 0; k < 9; k++) begin
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            t[k*32 +: 32] = lcg;
        end
        w = t[NW-1:0];
    endtask

    // One request; result read on the next falling edge.
    task automatic run(input logic mode, input logic [NW-1:0] w, output logic [17:0] res);
        @(negedge clk);
        in_valid = 1'b1; in_mode = mode; in_word = w;
        @(negedge clk);
        in_valid = 1'b0; in_word = '1;
        check(out_valid === 1'b1, "R2 valid after request", 18'(out_valid), 18'd1);
        check(out_mode === mode, "R9 mode echo", 18'(out_mode), 18'(mode));
        res = out_res;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_total++; n_fail++;
            $display("FAIL R2 watchdog expired actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

    initial begin
        logic [17:0]   res, res2, last;
        logic [NW-1:0] w, cw, e;
        repeat (3) @(negedge clk);
        check(out_valid === 1'b0 && out_res === '0, "R1 during reset", out_res, 18'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid === 1'b0 && out_res === '0, "R1 after release", out_res, 18'd0);

        // R3: every single data bit, and all-zero / all-one data.
        run(1'b0, '0, res);
        check(res === 18'd0, "R3 zero data", res, 18'd0);
        for (int j = 0; j < 256; j++) begin
            w = '0; w[18 + j] = 1'b1;
            run(1'b0, w, res);
            cw = {w[NW-1:18], res};
            check(synd(cw) === 18'd0, "R3 single data bit", synd(cw), 18'd0);
        end
        w = '1;
        run(1'b0, w, res);
        cw = {w[NW-1:18], res};
        check(synd(cw) === 18'd0, "R3 all ones", synd(cw), 18'd0);

        // R4, R7: random data with junk low bits, decode clean and corrupted.
        for (int n = 0; n < 40; n++) begin
            next_rand(w);
            run(1'b0, {w[NW-1:18], 18'd0}, res);
            run(1'b0, w, res2);
            check(res2 === res, "R4 low bits ignored", res2, res);
            cw = {w[NW-1:18], res};
            check(synd(cw) === 18'd0, "R3 random data", synd(cw), 18'd0);
            run(1'b1, cw, res2);
            check(res2 === 18'd0, "R7 clean codeword", res2, 18'd0);
            e = '0; e[(n * 37) % NW] = 1'b1; e[(n * 53 + 11) % NW] = 1'b1;
            if ((n * 37) % NW == (n * 53 + 11) % NW) e[0] = ~e[0];
            run(1'b1, cw ^ e, res2);
            check(res2 === synd(e), "R7 double error", res2, synd(e));
        end

        // R5, R6: single error at every position of the zero codeword.
        for (int i = 0; i < NW; i++) begin
            e = '0; e[i] = 1'b1;
            run(1'b1, e, res);
            check(res[8:0] === synd(e)[8:0], "R5 S1 single bit", 18'(res[8:0]), 18'(synd(e)[8:0]));
            check(res[17:9] === synd(e)[17:9], "R6 S3 single bit", 18'(res[17:9]), 18'(synd(e)[17:9]));
        end
        next_rand(w);
        run(1'b1, w, res);
        check(res === synd(w), "R5 R6 random received word", res, synd(w));

        // R9: encode then decode on consecutive cycles.
        next_rand(w);
        next_rand(e);
        @(negedge clk);
        in_valid = 1'b1; in_mode = 1'b0; in_word = w;
        @(negedge clk);
        res = out_res;
        cw = {w[NW-1:18], res};
        check(out_valid === 1'b1 && out_mode === 1'b0, "R9 back-to-back encode", 18'(out_mode), 18'd0);
        check(synd(cw) === 18'd0, "R9 back-to-back parity", synd(cw), 18'd0);
        in_mode = 1'b1; in_word = e;
        @(negedge clk);
        check(out_valid === 1'b1 && out_mode === 1'b1, "R9 back-to-back decode", 18'(out_mode), 18'd1);
        check(out_res === synd(e), "R9 back-to-back syndromes", out_res, synd(e));
        last = out_res;
        in_valid = 1'b0; in_mode = 1'b0; in_word = '1;

        // R8, R2: idle cycles hold the result and keep valid low.
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check(out_valid === 1'b0, "R2 idle valid low", 18'(out_valid), 18'd0);
            check(out_res === last, "R8 hold when idle", out_res, last);
        end

        done = 1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end
endmodule